// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status logic for a bank of DMA channels (four by default). Each channel owns one 8-bit register on a simple CPU register bus. The register has four parts. Bit 0 turns the channel on or off. Bit 1 is a write-only command that requests a software-started transfer. Bit 2 is a write-only command that resets the channel's transfer status. Bit 7 is a read-only flag that reports a finished block and clears when it is read. The transfer engine sits outside this block. It reports each transfer with an acknowledge pulse, plus a flag that marks the last transfer of a block. The block returns a per-channel enable level and single-cycle start and initialise pulses.

Each channel runs a three-state machine. In `CH_OFF` the channel is disabled. In `CH_ON` it is enabled. `CH_FINISH` is a one-cycle state that follows terminal count. The transitions are:
- `CH_OFF -> CH_ON` when a write sets bit 0.
- `CH_ON -> CH_OFF` when a write clears bit 0. This pauses the channel, and a later enable resumes it.
- `CH_ON -> CH_FINISH` on an acknowledge that carries the last-transfer mark. This takes priority over any write.
- `CH_FINISH -> CH_OFF` on the next cycle, which is also when the done flag is set.
- `CH_FINISH -> CH_ON` if that same cycle carries a write that sets bit 0.

Because of this ordering, enable drops one cycle before the flag rises, and a read in the gap returns 00h.

Top module: `dma_chctl`

## Requirements
- R1: After reset every channel register reads 00h and ch_en, ch_start and ch_init are all 0.
- R2: Writing bit 0 of a channel register as 1 or 0 sets or clears that channel's ch_en from the next cycle.
- R3: Writing 1 to bit 1 produces a one-cycle ch_start pulse in the cycle after the write, only if the channel is enabled and its done flag is 0; otherwise the command is ignored.
- R4: Writing 1 to bit 2 while the channel is disabled produces a one-cycle ch_init pulse and clears the done flag; while enabled the command is ignored.
- R5: Bits 1 through 6 always read as 0; writes to bits 3 through 7 have no effect.
- R6: An xfer_ack with xfer_last on an enabled channel clears ch_en in the next cycle, and the register reads 00h during that cycle.
- R7: The done flag is bit 7, is set one cycle after enable drops at terminal count, and is cleared by a read of the register, so a second read returns bit 7 as 0.
- R8: A read in the same cycle as the flag is being set does not clear it; the next read returns bit 7 as 1.
- R9: xfer_ack with xfer_last on a disabled (paused) channel is ignored; re-enabling resumes with ch_en high.
- R10: Channel n sits at byte offset 2n; odd offsets read 00h and writes to them are ignored.
- R11: A single write with bits 1 and 2 both set applies only initialise when disabled and only start when enabled.
- R12: Activity on one channel leaves the enable and flag of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (also triggers clear-on-read) |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| xfer_ack | input | 4 | Per-channel transfer acknowledge pulse |
| xfer_last | input | 4 | Per-channel last-transfer mark, valid with xfer_ack |
| ch_en | output | 4 | Per-channel enable level |
| ch_start | output | 4 | Per-channel software start pulse |
| ch_init | output | 4 | Per-channel status initialise pulse |

## Verification
Bit 0 is written alone, together with reserved bits, and to odd offsets. Comparing these cases separates real enable control from data leaking through the reserved field or address aliasing. Start and initialise are tried in four situations: channel disabled, channel enabled with the flag clear, channel enabled with the flag set, and both commands in one write. Each case isolates one gating condition. Terminal count is driven on an enabled channel and on a paused one, with reads placed in the gap cycle and right after it. This shows the enable-then-flag ordering, the set-wins rule and the clear-on-read rule as separate results.

// File: rtl/dma_chctl_pkg.sv
package dma_chctl_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_ON     = 2'd1,
        CH_FINISH = 2'd2
    } ch_state_e;

    localparam int BIT_EN    = 0;
    localparam int BIT_START = 1;
    localparam int BIT_INIT  = 2;
    localparam int BIT_DONE  = 7;
    localparam int REG_W     = 8;

endpackage

// File: rtl/dma_chctl_dec.sv
module dma_chctl_dec #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    sel
);
    localparam int IDX_W = ADDR_W - 1;

    // Registers sit on even byte offsets; an odd offset selects nothing.
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = !addr[0] && (addr[ADDR_W-1:1] == IDX_W'(i));
    end
endmodule

// File: rtl/dma_chctl_fsm.sv
module dma_chctl_fsm
    import dma_chctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic rd_hit,
    input  logic wr_en_bit,
    input  logic wr_start_bit,
    input  logic wr_init_bit,
    input  logic ack,
    input  logic last,
    output logic en_o,
    output logic flag_o,
    output logic start_o,
    output logic init_o
);
    ch_state_e state, state_d;
    logic      flag_q, flag_d;
    logic      start_q, init_q;
    logic      start_fire, init_fire;

    always_comb begin
        state_d = state;
        unique case (state)
            CH_OFF:    state_d = (wr_hit && wr_en_bit) ? CH_ON : CH_OFF;
            CH_ON: begin
                if (ack && last)                state_d = CH_FINISH;
                else if (wr_hit && !wr_en_bit)  state_d = CH_OFF;
                else                            state_d = CH_ON;
            end
            CH_FINISH: state_d = (wr_hit && wr_en_bit) ? CH_ON : CH_OFF;
            default:   state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= state_d;
    end

    assign en_o       = (state == CH_ON);
    assign start_fire = wr_hit && wr_start_bit && en_o && !flag_q;
    assign init_fire  = wr_hit && wr_init_bit && !en_o;

    // Setting from CH_FINISH outranks a same-cycle read or init clear.
    always_comb begin
        if (state == CH_FINISH)        flag_d = 1'b1;
        else if (rd_hit || init_fire)  flag_d = 1'b0;
        else                           flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            start_q <= 1'b0;
            init_q  <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            start_q <= start_fire;
            init_q  <= init_fire;
        end
    end

    assign flag_o  = flag_q;
    assign start_o = start_q;
    assign init_o  = init_q;

    p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($past(en_o) && !$past(flag_q)));

    p_init_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !$past(en_o));

    p_tc_drops_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && ack && last) |=> !en_o);

    p_tc_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && ack && last) |=> ##1 flag_o);

    p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OFF && !flag_o && !wr_hit) |=> !flag_o);
endmodule

// File: rtl/dma_chctl.sv
module dma_chctl
    import dma_chctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(NCH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    xfer_ack,
    input  logic [NCH-1:0]    xfer_last,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_init
);
    logic [NCH-1:0] sel;
    logic [NCH-1:0] flag;
    logic           wr_rsvd_any;

    dma_chctl_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chctl_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_hit       (bus_we && sel[i]),
            .rd_hit       (bus_re && sel[i]),
            .wr_en_bit    (bus_wdata[BIT_EN]),
            .wr_start_bit (bus_wdata[BIT_START]),
            .wr_init_bit  (bus_wdata[BIT_INIT]),
            .ack          (xfer_ack[i]),
            .last         (xfer_last[i]),
            .en_o         (ch_en[i]),
            .flag_o       (flag[i]),
            .start_o      (ch_start[i]),
            .init_o       (ch_init[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_re && sel[i]) begin
                bus_rdata[BIT_EN]   = ch_en[i];
                bus_rdata[BIT_DONE] = flag[i];
            end
        end
    end

    assign wr_rsvd_any = |bus_wdata[REG_W-1:BIT_INIT+1];

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BIT_DONE-1:BIT_START] == '0);

    p_rsvd_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && wr_rsvd_any && bus_wdata[BIT_INIT:BIT_START] == 2'b00)
        |=> (ch_start == '0 && ch_init == '0));

    p_odd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[0]) |-> (bus_rdata == '0));

    p_odd_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[0] && xfer_ack == '0) |=> $stable(ch_en));
endmodule

// File: tb/dma_chctl_test.sv
`timescale 1ns/1ps
module dma_chctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] xfer_ack = '0;
    logic [3:0] xfer_last = '0;
    logic [3:0] ch_en, ch_start, ch_init;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dma_chctl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .xfer_ack(xfer_ack), .xfer_last(xfer_last),
        .ch_en(ch_en), .ch_start(ch_start), .ch_init(ch_init)
    );

    // Vector: [23] read, [22:20] addr, [19:12] wdata, [11:4] expected, [3:0] req.
    // For writes the expected byte is {4'b0, ch_en} one cycle later.
    localparam logic [23:0] VEC [10] = '{
        {1'b1, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 reset read
        {1'b0, 3'd0, 8'h01, 8'h01, 4'd2},   // R2 enable ch0
        {1'b0, 3'd4, 8'h79, 8'h05, 4'd5},   // R5 reserved bits with enable ch2
        {1'b1, 3'd4, 8'h00, 8'h01, 4'd5},   // R5 reserved bits read 0
        {1'b0, 3'd3, 8'h01, 8'h05, 4'd10},  // R10 odd offset write ignored
        {1'b1, 3'd3, 8'h00, 8'h00, 4'd10},  // R10 odd offset reads 0
        {1'b0, 3'd2, 8'h00, 8'h05, 4'd2},   // R2 clear on disabled ch1
        {1'b0, 3'd0, 8'h00, 8'h04, 4'd2},   // R2 disable ch0
        {1'b1, 3'd0, 8'h00, 8'h00, 4'd2},   // R2 readback
        {1'b0, 3'd4, 8'h00, 8'h00, 4'd2}    // R2 disable ch2
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic tc_pulse(input int ch);
        @(negedge clk);
        xfer_ack = 4'(1 << ch); xfer_last = 4'(1 << ch);
        @(negedge clk);
        xfer_ack = '0; xfer_last = '0;
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ch_en", {4'b0, ch_en}, 8'h00);
        check("R1 pulses", {ch_start, ch_init}, 8'h00);

        for (int k = 0; k < 10; k++) begin
            logic [23:0] v = VEC[k];
            string tag = $sformatf("R%0d vec%0d", v[3:0], k);
            if (v[23]) begin
                do_read(v[22:20], rd);
                check(tag, rd, v[11:4]);
            end else begin
                do_write(v[22:20], v[19:12]);
                check(tag, {4'b0, ch_en}, v[11:4]);
            end
        end

        // R3: start ignored while disabled
        do_write(3'd4, 8'h02);
        check("R3 start when off", {4'b0, ch_start}, 8'h00);
        check("R3 en stays off", {4'b0, ch_en}, 8'h00);

        // R3: start on enabled channel, single cycle
        do_write(3'd2, 8'h01);
        do_write(3'd2, 8'h03);
        check("R3 start pulse", {4'b0, ch_start}, 8'h02);
        @(negedge clk);
        check("R3 pulse width", {4'b0, ch_start}, 8'h00);

        // R6/R8: terminal count on ch1, read inside the gap cycle
        tc_pulse(1);
        check("R6 en cleared", {4'b0, ch_en}, 8'h00);
        bus_addr = 3'd2; bus_re = 1'b1;
        #1 check("R6 gap read", bus_rdata, 8'h00);
        @(negedge clk);
        bus_re = 1'b0;
        do_read(3'd2, rd);
        check("R8 set wins", rd, 8'h80);
        do_read(3'd2, rd);
        check("R7 cleared by read", rd, 8'h00);

        // R9: pause ch3, ack ignored, resume
        do_write(3'd6, 8'h01);
        do_write(3'd6, 8'h00);
        tc_pulse(3);
        @(negedge clk);
        do_read(3'd6, rd);
        check("R9 paused ack", rd, 8'h00);
        do_write(3'd6, 8'h01);
        check("R9 resume", {4'b0, ch_en}, 8'h08);

        // R7/R3: completion then start blocked by flag
        tc_pulse(3);
        @(negedge clk);
        do_write(3'd6, 8'h01);
        do_write(3'd6, 8'h03);
        check("R3 start blocked by flag", {4'b0, ch_start}, 8'h00);
        do_read(3'd6, rd);
        check("R7 flag and enable", rd, 8'h81);
        do_write(3'd6, 8'h03);
        check("R3 start after clear", {4'b0, ch_start}, 8'h08);

        // R4: init when disabled clears flag
        do_write(3'd0, 8'h01);
        tc_pulse(0);
        @(negedge clk);
        check("R12 other channels", {4'b0, ch_en}, 8'h08);
        do_write(3'd0, 8'h04);
        check("R4 init pulse", {4'b0, ch_init}, 8'h01);
        do_read(3'd0, rd);
        check("R4 flag cleared", rd, 8'h00);
        do_write(3'd6, 8'h05);
        check("R4 init ignored when on", {4'b0, ch_init}, 8'h00);
        check("R4 en kept", {4'b0, ch_en}, 8'h08);

        // R11: combined commands
        do_write(3'd4, 8'h06);
        check("R11 off init", {4'b0, ch_init}, 8'h04);
        check("R11 off no start", {4'b0, ch_start}, 8'h00);
        do_write(3'd6, 8'h07);
        check("R11 on start", {4'b0, ch_start}, 8'h08);
        check("R11 on no init", {4'b0, ch_init}, 8'h00);

        // R12: only ch3 remains enabled, ch1 flag untouched
        check("R12 final en", {4'b0, ch_en}, 8'h08);
        do_read(3'd2, rd);
        check("R12 ch1 flag", rd, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule